// File: doc/BRIEF.md
# Reset Request Arbiter and Sequencer

This block gathers reset requests from eight origins and runs each accepted request as either a hard or a soft reset sequence. The origins are power-on, an external hard reset pad, an external soft reset pad, a test-port host command, a watchdog expiry, a serial-link reset request, and software strobes for hard and soft reset. Hard-class origins assert the hard pad, the soft pad and the core reset, and they strobe the configuration sample. Soft-class origins assert only the soft pad and the core reset, so the existing configuration is kept.

Both pads are open-drain. Each is modelled as an output enable that pulls the line low, together with the sampled pad level coming back in. While the block pulls a pad low it masks that pad from detection, and detection of both pads stays off for one cycle after the sequence ends. A configuration word is captured only while power-on is asserted. A status byte records which origins started the sequence now running or most recently completed.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `hard_oe`, `soft_oe` and `core_rst` are all 1. After `por_n` rises, a hard sequence runs and `rst_status` reads 0x01 (bit 0 = power-on).
- R2: `cfg_word` follows `cfg_in` only while `por_n` is low. It keeps its value through all later hard and soft sequences.
- R3: A hard-class request starts a sequence in which `hard_oe`, `soft_oe` and `core_rst` are all 1 and `cfg_sample` pulses for exactly one cycle, the last one. The hard-class requests are the hard pad read low, `wdog_exp_i`, `link_hard_i` and `sw_hard_i`.
- R4: A soft-class request asserts `soft_oe` and `core_rst` while `hard_oe` stays 0, and `cfg_sample` never pulses. The soft-class requests are the soft pad read low, `tap_soft_i` and `sw_soft_i`.
- R5: A pad read low is ignored during any sequence and during the first cycle after the sequence ends.
- R6: If hard-class and soft-class requests arrive in the same cycle, a hard sequence runs. A hard-class request during a soft sequence restarts it as a full hard sequence.
- R7: `rst_status` bit positions are: 0 power-on, 1 hard pad, 2 soft pad, 3 test-port command, 4 watchdog, 5 serial link, 6 software hard, 7 software soft. Every request accepted in the starting cycle is set together, and the new value replaces the old one. `rst_status` changes only when a sequence starts.
- R8: A request of any class during a hard sequence is ignored. A soft-class request during a soft sequence is ignored.
- R9: A sequence that is not restarted keeps `core_rst` high for exactly HOLD_CYCLES cycles (default 16). On the cycle after the final one, `core_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, sampled on the clock |
| hard_pad_i | input | 1 | Sampled level of the open-drain hard reset pad (low = asserted) |
| soft_pad_i | input | 1 | Sampled level of the open-drain soft reset pad (low = asserted) |
| tap_soft_i | input | 1 | Test-port host reset command, one-cycle pulse |
| wdog_exp_i | input | 1 | Watchdog expiry, one-cycle pulse |
| link_hard_i | input | 1 | Serial-link hard reset request, one-cycle pulse |
| sw_hard_i | input | 1 | Software hard reset write strobe, self-clearing |
| sw_soft_i | input | 1 | Software soft reset write strobe, self-clearing |
| cfg_in | input | CFG_W | Configuration word presented during power-on |
| hard_oe | output | 1 | Pull-low enable for the hard reset pad |
| soft_oe | output | 1 | Pull-low enable for the soft reset pad |
| core_rst | output | 1 | Core reset, active high |
| cfg_sample | output | 1 | System configuration sample strobe |
| cfg_word | output | CFG_W | Latched configuration word |
| rst_status | output | 8 | Origins of the current or last sequence |

## Verification
The assertions assume that the internal request strobes are single-cycle pulses. They also assume that each pad input is the wired-AND of the block's own pull-low and an external driver, so a pad always reads low while the block drives it. The bench builds each pad that way and drives every external pad assertion for a bounded number of cycles. It places the assertions on purpose inside a running sequence and in the first idle cycle after one. Because of this, no pad is still held low when detection resumes unless the test asks for it.

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int HOLD_CYCLES = 16,
  parameter int CFG_W       = 32
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             hard_pad_i,
  input  logic             soft_pad_i,
  input  logic             tap_soft_i,
  input  logic             wdog_exp_i,
  input  logic             link_hard_i,
  input  logic             sw_hard_i,
  input  logic             sw_soft_i,
  input  logic [CFG_W-1:0] cfg_in,
  output logic             hard_oe,
  output logic             soft_oe,
  output logic             core_rst,
  output logic             cfg_sample,
  output logic [CFG_W-1:0] cfg_word,
  output logic [7:0]       rst_status
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic             busy, busy_q, cls_hard;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       req;
  logic             pin_en, hard_req, soft_req, start;

  assign pin_en   = !busy && !busy_q;
  assign req      = {sw_soft_i, sw_hard_i, link_hard_i, wdog_exp_i, tap_soft_i,
                     pin_en & ~soft_pad_i, pin_en & ~hard_pad_i, 1'b0};
  assign hard_req = req[6] | req[5] | req[4] | req[1];
  assign soft_req = req[7] | req[3] | req[2];
  assign start    = busy ? (!cls_hard && hard_req) : (hard_req || soft_req);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      busy       <= 1'b1;
      busy_q     <= 1'b1;
      cls_hard   <= 1'b1;
      cnt        <= LAST;
      rst_status <= 8'h01;
      cfg_word   <= cfg_in;
    end else begin
      busy_q <= busy;
      if (start) begin
        busy       <= 1'b1;
        cls_hard   <= hard_req;
        cnt        <= LAST;
        rst_status <= req;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  assign hard_oe    = !por_n || (busy && cls_hard);
  assign soft_oe    = !por_n || busy;
  assign core_rst   = !por_n || busy;
  assign cfg_sample = por_n && busy && cls_hard && (cnt == '0);
endmodule

module rst_seq_ctrl_chk #(
  parameter int HOLD_CYCLES = 16,
  parameter int CFG_W       = 32
) (
  input logic             clk,
  input logic             por_n,
  input logic             hard_oe,
  input logic             core_rst,
  input logic             cfg_sample,
  input logic [CFG_W-1:0] cfg_word,
  input logic [7:0]       rst_status
);
  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (!por_n)                     run_len <= '0;
    else if (!core_rst)             run_len <= '0;
    else if (run_len != 16'hFFFF)   run_len <= run_len + 16'd1;
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> $stable(cfg_word));

  // R3
  sample_in_hard_chk: assert property (@(posedge clk) disable iff (!por_n)
    cfg_sample |-> (hard_oe && core_rst));

  // R9
  release_after_sample_chk: assert property (@(posedge clk) disable iff (!por_n)
    cfg_sample |=> !core_rst);

  // R9
  min_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst) |-> (run_len >= 16'(HOLD_CYCLES)));

  // R7
  status_on_start_chk: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(rst_status) |-> core_rst);
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES), .CFG_W(CFG_W)) chk_i (
  .clk(clk), .por_n(por_n), .hard_oe(hard_oe), .core_rst(core_rst),
  .cfg_sample(cfg_sample), .cfg_word(cfg_word), .rst_status(rst_status)
);

// File: tb/rst_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb_top;
  localparam int HOLD  = 16;
  localparam int CFG_W = 32;

  typedef struct packed {
    logic [7:0] st;
    logic       hard;
    int         len;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             por_n = 1'b0;
  logic [7:0]       drv = '0;
  logic [CFG_W-1:0] cfg_in = 32'hA5C3_0F1E;
  logic hard_oe, soft_oe, core_rst, cfg_sample;
  logic [CFG_W-1:0] cfg_word;
  logic [7:0] rst_status;
  logic hard_pad, soft_pad;

  assign hard_pad = !(hard_oe || drv[1]);
  assign soft_pad = !(soft_oe || drv[2]);

  rst_seq_ctrl #(.HOLD_CYCLES(HOLD), .CFG_W(CFG_W)) dut_i (
    .clk(clk), .por_n(por_n), .hard_pad_i(hard_pad), .soft_pad_i(soft_pad),
    .tap_soft_i(drv[3]), .wdog_exp_i(drv[4]), .link_hard_i(drv[5]),
    .sw_hard_i(drv[6]), .sw_soft_i(drv[7]), .cfg_in(cfg_in),
    .hard_oe(hard_oe), .soft_oe(soft_oe), .core_rst(core_rst),
    .cfg_sample(cfg_sample), .cfg_word(cfg_word), .rst_status(rst_status)
  );

  int   n_chk = 0, n_bad = 0;
  bit   ended = 0;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] st, input logic hard, input int len);
    exp_t e;
    e.st = st; e.hard = hard; e.len = len;
    exp_q.push_back(e);
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk) drv = m;
    @(negedge clk) drv = '0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (core_rst) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: measures every sequence and compares it with the queue
  initial begin
    int   len = 0, nsamp = 0;
    bit   in_seq = 0, saw_hard = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (core_rst) begin
        in_seq = 1; len++;
        if (hard_oe)    saw_hard = 1;
        if (cfg_sample) nsamp++;
      end else if (in_seq) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected sequence", 32'(rst_status), 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(rst_status == e.st, "R7 status", 32'(rst_status), 32'(e.st));
          chk(saw_hard == e.hard, e.hard ? "R3 hard pad driven" : "R4 hard pad quiet",
              32'(saw_hard), 32'(e.hard));
          chk(nsamp == (e.hard ? 1 : 0), "R3 R4 config sample count", 32'(nsamp),
              32'(e.hard ? 1 : 0));
          if (e.len != 0) chk(len == e.len, "R9 hold length", 32'(len), 32'(e.len));
        end
        in_seq = 0; len = 0; saw_hard = 0; nsamp = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      chk(0, "watchdog", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(hard_oe && soft_oe && core_rst, "R1 outputs during power-on",
        {29'b0, hard_oe, soft_oe, core_rst}, 32'h7);
    push(8'h01, 1'b1, 0);
    por_n = 1'b1;
    wait_idle();
    // R2
    chk(cfg_word == 32'hA5C3_0F1E, "R2 captured word", cfg_word, 32'hA5C3_0F1E);
    cfg_in = 32'h1234_5678;

    push(8'h02, 1'b1, HOLD); pulse(8'h02); wait_idle();          // R3 hard pad
    chk(cfg_word == 32'hA5C3_0F1E, "R2 word kept after hard", cfg_word, 32'hA5C3_0F1E);
    push(8'h04, 1'b0, HOLD); pulse(8'h04); wait_idle();          // R4 soft pad
    push(8'h10, 1'b1, HOLD); pulse(8'h10); wait_idle();          // R3 watchdog
    push(8'h20, 1'b1, HOLD); pulse(8'h20); wait_idle();          // R3 link
    push(8'h40, 1'b1, HOLD); pulse(8'h40); wait_idle();          // R3 sw hard
    push(8'h80, 1'b0, HOLD); pulse(8'h80); wait_idle();          // R4 sw soft
    push(8'h08, 1'b0, HOLD); pulse(8'h08); wait_idle();          // R4 test port

    push(8'hC8, 1'b1, HOLD); pulse(8'hC8); wait_idle();          // R6 same-cycle priority

    push(8'h10, 1'b1, 4 + HOLD);                                 // R6 escalation
    pulse(8'h08); repeat (2) @(negedge clk); pulse(8'h10); wait_idle();

    push(8'h10, 1'b1, HOLD);                                     // R8 during hard
    pulse(8'h10); repeat (3) @(negedge clk); pulse(8'h20); pulse(8'h80); wait_idle();
    push(8'h80, 1'b0, HOLD);                                     // R8 soft during soft
    pulse(8'h80); repeat (3) @(negedge clk); pulse(8'h08); wait_idle();

    push(8'h08, 1'b0, HOLD);                                     // R5 pads during sequence
    pulse(8'h08);
    @(negedge clk) drv = 8'h06;
    repeat (3) @(negedge clk);
    drv = '0;
    wait_idle();

    push(8'h08, 1'b0, HOLD);                                     // R5 first idle cycle
    pulse(8'h08);
    while (core_rst) @(negedge clk);
    drv = 8'h04;
    @(negedge clk) drv = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!core_rst, "R5 pad masked after release", 32'(core_rst), 32'h0);
    end
    chk(rst_status == 8'h08, "R7 status kept while idle", 32'(rst_status), 32'h08);
    chk(cfg_word == 32'hA5C3_0F1E, "R2 word kept at end", cfg_word, 32'hA5C3_0F1E);
    chk(exp_q.size() == 0, "R9 all sequences seen", 32'(exp_q.size()), 32'h0);

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule